// File: doc/BRIEF.md
# Segment Descriptor Restore Unit

This execution-unit block performs the privileged operation that reloads one segment register, both its visible selector and its hidden descriptor cache, from an 80-bit memory operand. The decoder presents a request with a 3-bit segment number. The block checks privilege and operating mode. A refused request raises an invalid-opcode fault for one cycle and leaves all state as it was. An accepted request runs for a fixed 11 clocks. During that time the memory side supplies the operand as three words. On the final clock the block writes the unpacked fields into the chosen register. No field of the operand is checked for validity.

Two registers have side effects. Restoring the stack segment (SS) copies the descriptor's privilege field into the current privilege level. Restoring the code segment (CS) uses the new limit at once, but the new base waits in a staging register until the next pipeline flush. A CS restore also raises an interrupt hold that stays set until the table-load operation that follows it reports completion. A combinational read port lets the surrounding core read any register.

Top module: `seg_restore_unit`

## Requirements
- R1: The segment number maps as 0=ES, 1=CS, 2=SS, 3=DS, 4=FS, 5=GS. Each restore writes only the register it names. Numbers 6 and 7 raise `fault_ud_o` in the cycle after the request and change no state.
- R2: A request is refused with `fault_ud_o` when `cpl_o` is nonzero. It is also refused when `spec_en_i` is 0 while both `sys_mgmt_i` and `dbg_mgmt_i` are 0. A refused request never sets `busy_o` and changes no register. Either mode input alone makes the request legal again.
- R3: The operand is unpacked as follows. Word 0 gives base[15:0] in bits 31:16 and limit[15:0] in bits 15:0. Word 1 gives base[31:24] in 31:24, G in 23, B in 22, V in 20, limit[19:16] in 19:16, DPL in 14:13, X in 11, E in 10, W in 9, A in 8 and base[23:16] in 7:0. Bits 15:0 of word 2 give the selector. `rd_attr_o` reads back as {G,B,V,DPL[1:0],X,E,W,A}, with G in bit 8.
- R4: Bits 21, 15 and 12 of word 1 are ignored. The fields load unchanged whatever values those bits carry.
- R5: A completed SS restore sets `cpl_o` to the loaded DPL in the done cycle. Restores of other registers leave `cpl_o` unchanged.
- R6: A completed CS restore updates the CS selector, limit and attributes at once and sets `cs_base_pend_o`. The CS base shown on the read port changes only when `flush_i` is sampled high, which also clears `cs_base_pend_o`.
- R7: When `flush_i` coincides with the commit of a CS restore, the flush applies the base that was already pending, if there is one. The new base then becomes pending.
- R8: A completed CS restore sets `irq_hold_o`. A flush leaves it set. It clears on the clock after `ldt_done_i` is sampled high.
- R9: On acceptance, `busy_o` rises on the next clock. `done_o` is a one-cycle pulse in the eleventh clock counted from the accept cycle. `busy_o` falls in that same cycle.
- R10: `rd_writable_o` is W AND NOT X of the selected register, so a register loaded with X=1 reads as non-writable.
- R11: After reset all registers, `cpl_o`, `busy_o`, `done_o`, `fault_ud_o`, `irq_hold_o` and `cs_base_pend_o` read 0.
- R12: A request presented while `busy_o` is high is ignored. It raises no fault and writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Restore request strobe |
| req_sel_i | input | 3 | Segment number |
| spec_en_i | input | 1 | Special-instruction enable |
| sys_mgmt_i | input | 1 | Processor is in system-management mode |
| dbg_mgmt_i | input | 1 | Processor is in debug-management mode |
| op_valid_i | input | 1 | Operand word strobe |
| op_word_i | input | 32 | Operand word, delivered in the order +0, +4, +8 |
| flush_i | input | 1 | Pipeline flush or non-sequential fetch |
| ldt_done_i | input | 1 | Following table-load operation completed |
| rd_sel_i | input | 3 | Read-port segment number |
| busy_o | output | 1 | Restore in progress |
| done_o | output | 1 | Restore completion pulse |
| fault_ud_o | output | 1 | Invalid-opcode fault pulse |
| cpl_o | output | 2 | Current privilege level |
| irq_hold_o | output | 1 | Interrupts, single-step and debug traps held off |
| cs_base_pend_o | output | 1 | A CS base is waiting for a flush |
| rd_selector_o | output | 16 | Selector of the read register |
| rd_base_o | output | 32 | Committed base of the read register |
| rd_limit_o | output | 20 | Limit of the read register |
| rd_attr_o | output | 9 | Attributes {G,B,V,DPL,X,E,W,A} |
| rd_writable_o | output | 1 | Read register is writable |

## Verification
The commit of a CS restore and a pipeline flush can fall on the same clock edge. The bench first leaves one CS base pending. It then runs a second CS restore and holds `flush_i` high exactly on its commit clock. It judges the result by reading the port: the committed base must equal the first restore's value and `cs_base_pend_o` must still be set. A further flush must then expose the second base. The interrupt hold is also checked against a flush in a cycle of its own, and must stay set until `ldt_done_i` arrives.

// File: rtl/seg_restore_pkg.sv
package seg_restore_pkg;
  localparam int SEL_W      = 3;
  localparam int NUM_SEG    = 6;
  localparam int OP_W       = 32;
  localparam int SEQ_CLOCKS = 11;

  localparam logic [SEL_W-1:0] SEG_ES = 3'd0;
  localparam logic [SEL_W-1:0] SEG_CS = 3'd1;
  localparam logic [SEL_W-1:0] SEG_SS = 3'd2;

  typedef struct packed {
    logic       g;
    logic       b;
    logic       v;
    logic [1:0] dpl;
    logic       x;
    logic       e;
    logic       w;
    logic       a;
  } seg_attr_t;

  typedef struct packed {
    logic [15:0] selector;
    logic [31:0] base;
    logic [19:0] limit;
    seg_attr_t   attr;
  } seg_desc_t;
endpackage

// File: rtl/seg_desc_unpack.sv
module seg_desc_unpack
  import seg_restore_pkg::*;
(
  input  logic [OP_W-1:0] w0_i,
  input  logic [OP_W-1:0] w1_i,
  input  logic [15:0]     w2_i,
  output seg_desc_t       desc_o
);
  // fixed-value bits of word 1 are ignored
  logic unused_fixed;
  assign unused_fixed = ^{w1_i[21], w1_i[15], w1_i[12]};

  always_comb begin
    desc_o.selector  = w2_i;
    desc_o.base      = {w1_i[31:24], w1_i[7:0], w0_i[31:16]};
    desc_o.limit     = {w1_i[19:16], w0_i[15:0]};
    desc_o.attr.g    = w1_i[23];
    desc_o.attr.b    = w1_i[22];
    desc_o.attr.v    = w1_i[20];
    desc_o.attr.dpl  = w1_i[14:13];
    desc_o.attr.x    = w1_i[11];
    desc_o.attr.e    = w1_i[10];
    desc_o.attr.w    = w1_i[9];
    desc_o.attr.a    = w1_i[8];
  end
endmodule

// File: rtl/seg_restore_ctrl.sv
module seg_restore_ctrl
  import seg_restore_pkg::*;
#(
  parameter int LAT  = SEQ_CLOCKS,
  parameter int NSEG = NUM_SEG
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic [SEL_W-1:0] req_sel_i,
  input  logic [1:0]       cpl_i,
  input  logic             spec_en_i,
  input  logic             sys_mgmt_i,
  input  logic             dbg_mgmt_i,
  input  logic             op_valid_i,
  input  logic [OP_W-1:0]  op_word_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             fault_o,
  output logic             commit_o,
  output logic [SEL_W-1:0] sel_o,
  output logic [OP_W-1:0]  w0_o,
  output logic [OP_W-1:0]  w1_o,
  output logic [15:0]      w2_o
);
  localparam int               CNT_W = $clog2(LAT + 1);
  localparam logic [CNT_W-1:0] LAST  = CNT_W'(LAT - 1);

  logic             busy_q, done_q, fault_q;
  logic [CNT_W-1:0] cnt_q;
  logic [SEL_W-1:0] sel_q;
  logic [1:0]       idx_q;
  logic [OP_W-1:0]  w0_q, w1_q;
  logic [15:0]      w2_q;
  logic             accept, refuse, commit;

  assign accept = req_valid_i && !busy_q;
  assign refuse = (req_sel_i >= SEL_W'(NSEG)) || (cpl_i != 2'd0) ||
                  (!spec_en_i && !sys_mgmt_i && !dbg_mgmt_i);
  assign commit = busy_q && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      fault_q <= 1'b0;
      cnt_q   <= '0;
      sel_q   <= '0;
    end else begin
      done_q  <= commit;
      fault_q <= accept && refuse;
      if (accept && !refuse) begin
        busy_q <= 1'b1;
        cnt_q  <= CNT_W'(1);
        sel_q  <= req_sel_i;
      end else if (busy_q) begin
        if (commit) busy_q <= 1'b0;
        else        cnt_q  <= cnt_q + CNT_W'(1);
      end
    end
  end

  // operand words arrive in address order
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= '0;
      w0_q  <= '0;
      w1_q  <= '0;
      w2_q  <= '0;
    end else if (accept && !refuse) begin
      idx_q <= '0;
    end else if (busy_q && op_valid_i) begin
      case (idx_q)
        2'd0: begin w0_q <= op_word_i;        idx_q <= 2'd1; end
        2'd1: begin w1_q <= op_word_i;        idx_q <= 2'd2; end
        2'd2: begin w2_q <= op_word_i[15:0];  idx_q <= 2'd3; end
        default: ;
      endcase
    end
  end

  assign busy_o   = busy_q;
  assign done_o   = done_q;
  assign fault_o  = fault_q;
  assign commit_o = commit;
  assign sel_o    = sel_q;
  assign w0_o     = w0_q;
  assign w1_o     = w1_q;
  assign w2_o     = w2_q;
endmodule

// File: rtl/seg_reg_file.sv
module seg_reg_file
  import seg_restore_pkg::*;
#(
  parameter int               NSEG   = NUM_SEG,
  parameter logic [SEL_W-1:0] CS_IDX = SEG_CS
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [SEL_W-1:0] wr_sel_i,
  input  seg_desc_t        wr_desc_i,
  input  logic             flush_i,
  input  logic [SEL_W-1:0] rd_sel_i,
  output seg_desc_t        rd_desc_o,
  output logic             pend_o
);
  seg_desc_t   seg_q [NSEG];
  logic        pend_q;
  logic [31:0] pend_base_q;

  // staged code-segment base
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q      <= 1'b0;
      pend_base_q <= '0;
    end else if (wr_en_i && wr_sel_i == CS_IDX) begin
      pend_q      <= 1'b1;
      pend_base_q <= wr_desc_i.base;
    end else if (flush_i && pend_q) begin
      pend_q      <= 1'b0;
    end
  end

  for (genvar i = 0; i < NSEG; i++) begin : g_seg
    seg_desc_t q;
    logic      hit;
    assign hit = wr_en_i && (wr_sel_i == SEL_W'(i));

    if (SEL_W'(i) == CS_IDX) begin : g_cs
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          q <= '0;
        end else begin
          if (hit) begin
            q.selector <= wr_desc_i.selector;
            q.limit    <= wr_desc_i.limit;
            q.attr     <= wr_desc_i.attr;
          end
          if (flush_i && pend_q) q.base <= pend_base_q;
        end
      end
    end else begin : g_std
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)  q <= '0;
        else if (hit) q <= wr_desc_i;
      end
    end

    assign seg_q[i] = q;
  end

  always_comb begin
    rd_desc_o = '0;
    for (int i = 0; i < NSEG; i++) begin
      if (rd_sel_i == SEL_W'(i)) rd_desc_o = seg_q[i];
    end
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/seg_restore_unit.sv
module seg_restore_unit
  import seg_restore_pkg::*;
#(
  parameter int LAT  = SEQ_CLOCKS,
  parameter int NSEG = NUM_SEG
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_valid_i,
  input  logic [2:0]  req_sel_i,
  input  logic        spec_en_i,
  input  logic        sys_mgmt_i,
  input  logic        dbg_mgmt_i,
  input  logic        op_valid_i,
  input  logic [31:0] op_word_i,
  input  logic        flush_i,
  input  logic        ldt_done_i,
  input  logic [2:0]  rd_sel_i,
  output logic        busy_o,
  output logic        done_o,
  output logic        fault_ud_o,
  output logic [1:0]  cpl_o,
  output logic        irq_hold_o,
  output logic        cs_base_pend_o,
  output logic [15:0] rd_selector_o,
  output logic [31:0] rd_base_o,
  output logic [19:0] rd_limit_o,
  output logic [8:0]  rd_attr_o,
  output logic        rd_writable_o
);
  logic             commit;
  logic [SEL_W-1:0] sel;
  logic [OP_W-1:0]  w0, w1;
  logic [15:0]      w2;
  seg_desc_t        new_desc, rd_desc;
  logic [1:0]       cpl_q;
  logic             irq_q;

  seg_restore_ctrl #(.LAT(LAT), .NSEG(NSEG)) u_ctrl (
    .clk_i, .rst_ni, .req_valid_i, .req_sel_i,
    .cpl_i      (cpl_q),
    .spec_en_i, .sys_mgmt_i, .dbg_mgmt_i, .op_valid_i, .op_word_i,
    .busy_o, .done_o,
    .fault_o    (fault_ud_o),
    .commit_o   (commit),
    .sel_o      (sel),
    .w0_o       (w0),
    .w1_o       (w1),
    .w2_o       (w2)
  );

  seg_desc_unpack u_unpack (
    .w0_i   (w0),
    .w1_i   (w1),
    .w2_i   (w2),
    .desc_o (new_desc)
  );

  seg_reg_file #(.NSEG(NSEG), .CS_IDX(SEG_CS)) u_regs (
    .clk_i, .rst_ni,
    .wr_en_i   (commit),
    .wr_sel_i  (sel),
    .wr_desc_i (new_desc),
    .flush_i,
    .rd_sel_i,
    .rd_desc_o (rd_desc),
    .pend_o    (cs_base_pend_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cpl_q <= 2'd0;
      irq_q <= 1'b0;
    end else begin
      if (commit && sel == SEG_SS) cpl_q <= new_desc.attr.dpl;
      // a new CS restore wins over a completing table load
      if (commit && sel == SEG_CS) irq_q <= 1'b1;
      else if (ldt_done_i)         irq_q <= 1'b0;
    end
  end

  assign cpl_o         = cpl_q;
  assign irq_hold_o    = irq_q;
  assign rd_selector_o = rd_desc.selector;
  assign rd_base_o     = rd_desc.base;
  assign rd_limit_o    = rd_desc.limit;
  assign rd_attr_o     = rd_desc.attr;
  assign rd_writable_o = rd_desc.attr.w & ~rd_desc.attr.x;
endmodule

// File: rtl/seg_restore_chk.sv
module seg_restore_chk #(
  parameter int LAT = 11
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       req_valid_i,
  input logic [2:0] req_sel_i,
  input logic       flush_i,
  input logic       ldt_done_i,
  input logic       busy_o,
  input logic       done_o,
  input logic       fault_ud_o,
  input logic [1:0] cpl_o,
  input logic       irq_hold_o,
  input logic       cs_base_pend_o
);
  logic [7:0] busy_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     busy_cnt <= '0;
    else if (busy_o) busy_cnt <= busy_cnt + 8'd1;
    else             busy_cnt <= '0;
  end

  p_busy_done_excl_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_o && done_o));
  p_done_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_latency_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> busy_cnt == 8'(LAT - 1));
  p_bad_sel_fault_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !busy_o && req_sel_i > 3'd5) |=> (fault_ud_o && !busy_o));
  p_cpl_fault_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !busy_o && cpl_o != 2'd0) |=> fault_ud_o);
  p_fault_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_ud_o |-> !busy_o);
  p_cpl_change_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cpl_o) |-> done_o);
  p_pend_rise_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cs_base_pend_o) |-> done_o);
  p_pend_fall_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_base_pend_o) |-> $past(flush_i));
  p_hold_rise_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_hold_o) |-> done_o);
  p_hold_fall_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(irq_hold_o) |-> $past(ldt_done_i));
  p_busy_ignore_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o) |=> !fault_ud_o);
endmodule

bind seg_restore_unit seg_restore_chk #(.LAT(LAT)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .req_valid_i    (req_valid_i),
  .req_sel_i      (req_sel_i),
  .flush_i        (flush_i),
  .ldt_done_i     (ldt_done_i),
  .busy_o         (busy_o),
  .done_o         (done_o),
  .fault_ud_o     (fault_ud_o),
  .cpl_o          (cpl_o),
  .irq_hold_o     (irq_hold_o),
  .cs_base_pend_o (cs_base_pend_o)
);

// File: tb/seg_restore_unit_tb_top.sv
`timescale 1ns/1ps
module seg_restore_unit_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic [2:0]  req_sel_i = '0;
  logic        spec_en_i = 1'b1;
  logic        sys_mgmt_i = 1'b0;
  logic        dbg_mgmt_i = 1'b0;
  logic        op_valid_i = 1'b0;
  logic [31:0] op_word_i = '0;
  logic        flush_i = 1'b0;
  logic        ldt_done_i = 1'b0;
  logic [2:0]  rd_sel_i = '0;
  logic        busy_o, done_o, fault_ud_o, irq_hold_o, cs_base_pend_o, rd_writable_o;
  logic [1:0]  cpl_o;
  logic [15:0] rd_selector_o;
  logic [31:0] rd_base_o;
  logic [19:0] rd_limit_o;
  logic [8:0]  rd_attr_o;

  int checks = 0;
  int errors = 0;

  always #10 clk_i = ~clk_i;

  seg_restore_unit dut_i (.*);

  typedef struct packed {
    logic [2:0]  sel;
    logic [31:0] base;
    logic [19:0] limit;
    logic [8:0]  attr;
    logic [15:0] selr;
  } vec_t;

  localparam vec_t VEC [4] = '{
    '{3'd0, 32'h1234_5678, 20'hABCDE, 9'h147, 16'h0013},
    '{3'd3, 32'hFEDC_BA98, 20'h00FFF, 9'h08A, 16'hBEEF},
    '{3'd4, 32'h0000_8000, 20'hFFFFF, 9'h1FF, 16'hFFFF},
    '{3'd5, 32'hA5A5_5A5A, 20'h50A0A, 9'h002, 16'h0004}
  };

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // attr = {G,B,V,DPL[1:0],X,E,W,A}
  function automatic logic [31:0] pack_w1(input logic [31:0] b, input logic [19:0] l, input logic [8:0] a);
    return {b[31:24], a[8], a[7], 1'b0, a[6], l[19:16], 1'b1, a[5:4], 1'b1, a[3:0], b[23:16]};
  endfunction

  task automatic rd(input logic [2:0] s);
    rd_sel_i = s;
    #1;
  endtask

  task automatic check_entry(input logic [2:0] s, input logic [31:0] b, input logic [19:0] l,
                             input logic [8:0] a, input logic [15:0] sr, input string req);
    rd(s);
    chk(rd_selector_o == sr, req, 64'(rd_selector_o), 64'(sr));
    chk(rd_base_o == b,      req, 64'(rd_base_o),     64'(b));
    chk(rd_limit_o == l,     req, 64'(rd_limit_o),    64'(l));
    chk(rd_attr_o == a,      req, 64'(rd_attr_o),     64'(a));
  endtask

  // accept at E0, words on E1..E3, commit on E10
  task automatic restore(input logic [2:0] s, input logic [31:0] w0, input logic [31:0] w1,
                         input logic [31:0] w2, input bit fl, input bit intrude);
    @(negedge clk_i);
    req_valid_i = 1'b1;
    req_sel_i   = s;
    @(posedge clk_i);
    @(negedge clk_i);
    req_valid_i = 1'b0;
    chk(busy_o == 1'b1, "R9 busy after accept", 64'(busy_o), 64'd1);
    for (int k = 1; k <= 10; k++) begin
      op_valid_i  = (k <= 3);
      op_word_i   = (k == 1) ? w0 : (k == 2) ? w1 : w2;
      flush_i     = fl && (k == 10);
      req_valid_i = intrude && (k == 5);
      req_sel_i   = intrude ? 3'd5 : s;
      @(posedge clk_i);
      @(negedge clk_i);
      if (k == 9) chk(busy_o && !done_o, "R9 busy before done", 64'({busy_o, done_o}), 64'b10);
      if (k == 5 && intrude) chk(!fault_ud_o, "R12 no fault while busy", 64'(fault_ud_o), 64'd0);
    end
    op_valid_i  = 1'b0;
    flush_i     = 1'b0;
    req_valid_i = 1'b0;
    chk(done_o && !busy_o, "R9 done on eleventh clock", 64'({done_o, busy_o}), 64'b10);
    @(posedge clk_i);
    @(negedge clk_i);
    chk(!done_o, "R9 done is a pulse", 64'(done_o), 64'd0);
  endtask

  task automatic try_fault(input logic [2:0] s, input string req);
    @(negedge clk_i);
    req_valid_i = 1'b1;
    req_sel_i   = s;
    @(posedge clk_i);
    @(negedge clk_i);
    req_valid_i = 1'b0;
    chk(fault_ud_o && !busy_o, req, 64'({fault_ud_o, busy_o}), 64'b10);
    @(posedge clk_i);
    @(negedge clk_i);
    chk(!fault_ud_o && !busy_o, req, 64'({fault_ud_o, busy_o}), 64'b00);
  endtask

  task automatic pulse(input bit is_flush);
    @(negedge clk_i);
    if (is_flush) flush_i = 1'b1; else ldt_done_i = 1'b1;
    @(posedge clk_i);
    @(negedge clk_i);
    flush_i    = 1'b0;
    ldt_done_i = 1'b0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk_i);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R11 reset state
    chk({busy_o, done_o, fault_ud_o, irq_hold_o, cs_base_pend_o} == 5'b0, "R11 reset flags",
        64'({busy_o, done_o, fault_ud_o, irq_hold_o, cs_base_pend_o}), 64'd0);
    chk(cpl_o == 2'd0, "R11 reset cpl", 64'(cpl_o), 64'd0);
    for (int s = 0; s < 6; s++) check_entry(3'(s), '0, '0, '0, '0, "R11 reset entry");

    // R3 R10 table of vectors
    foreach (VEC[i]) begin
      restore(VEC[i].sel, {VEC[i].base[15:0], VEC[i].limit[15:0]},
              pack_w1(VEC[i].base, VEC[i].limit, VEC[i].attr), {16'h0, VEC[i].selr}, 1'b0, 1'b0);
      check_entry(VEC[i].sel, VEC[i].base, VEC[i].limit, VEC[i].attr, VEC[i].selr, "R3 unpack");
      chk(rd_writable_o == (VEC[i].attr[1] & ~VEC[i].attr[3]), "R10 writable",
          64'(rd_writable_o), 64'(VEC[i].attr[1] & ~VEC[i].attr[3]));
      chk(cpl_o == 2'd0, "R5 cpl kept on non-SS", 64'(cpl_o), 64'd0);
    end

    // R1 mapping: each restore landed only in its own register
    foreach (VEC[i]) check_entry(VEC[i].sel, VEC[i].base, VEC[i].limit, VEC[i].attr, VEC[i].selr, "R1 mapping");
    check_entry(3'd1, '0, '0, '0, '0, "R1 CS untouched");
    check_entry(3'd2, '0, '0, '0, '0, "R1 SS untouched");

    // R4 fixed bits inverted
    restore(3'd3, 32'h1111_2222, pack_w1(32'h3344_1111, 20'h72222, 9'h0C5) ^ 32'h0020_9000,
            32'h0000_0A0B, 1'b0, 1'b0);
    check_entry(3'd3, 32'h3344_1111, 20'h72222, 9'h0C5, 16'h0A0B, "R4 fixed bits ignored");

    // R12 request during busy is ignored
    restore(3'd0, 32'h0, pack_w1(32'h0, 20'h0, 9'h0), 32'h0000_0042, 1'b0, 1'b1);
    check_entry(3'd5, VEC[3].base, VEC[3].limit, VEC[3].attr, VEC[3].selr, "R12 GS unchanged");
    check_entry(3'd0, 32'h0, 20'h0, 9'h0, 16'h0042, "R12 ES target");

    // R6 R8 CS base staging and interrupt hold
    restore(3'd1, 32'hAAAA_0123, pack_w1(32'hCCBB_AAAA, 20'h30123, 9'h00A), 32'h0000_0008, 1'b0, 1'b0);
    check_entry(3'd1, 32'h0, 20'h30123, 9'h00A, 16'h0008, "R6 limit now base old");
    chk(cs_base_pend_o, "R6 pending set", 64'(cs_base_pend_o), 64'd1);
    chk(irq_hold_o, "R8 hold set", 64'(irq_hold_o), 64'd1);
    chk(rd_writable_o == 1'b0, "R10 X set", 64'(rd_writable_o), 64'd0);
    pulse(1'b1);
    rd(3'd1);
    chk(rd_base_o == 32'hCCBB_AAAA, "R6 base after flush", 64'(rd_base_o), 64'hCCBB_AAAA);
    chk(!cs_base_pend_o, "R6 pending cleared", 64'(cs_base_pend_o), 64'd0);
    chk(irq_hold_o, "R8 hold survives flush", 64'(irq_hold_o), 64'd1);
    pulse(1'b0);
    chk(!irq_hold_o, "R8 hold cleared by table load", 64'(irq_hold_o), 64'd1 ^ 64'd1);

    // R7 flush coinciding with CS commit
    restore(3'd1, 32'h1000_0000, pack_w1(32'h0101_1000, 20'h0, 9'h002), 32'h10, 1'b0, 1'b0);
    restore(3'd1, 32'h2000_0000, pack_w1(32'h0202_2000, 20'h0, 9'h002), 32'h18, 1'b1, 1'b0);
    rd(3'd1);
    chk(rd_base_o == 32'h0101_1000, "R7 old pending applied", 64'(rd_base_o), 64'h0101_1000);
    chk(cs_base_pend_o, "R7 new base pending", 64'(cs_base_pend_o), 64'd1);
    pulse(1'b1);
    rd(3'd1);
    chk(rd_base_o == 32'h0202_2000, "R7 new base after flush", 64'(rd_base_o), 64'h0202_2000);

    // R1 unrecognised numbers
    try_fault(3'd6, "R1 sel 6 fault");
    try_fault(3'd7, "R1 sel 7 fault");

    // R2 mode gating
    spec_en_i = 1'b0;
    try_fault(3'd4, "R2 mode fault");
    check_entry(3'd4, VEC[2].base, VEC[2].limit, VEC[2].attr, VEC[2].selr, "R2 FS unchanged");
    sys_mgmt_i = 1'b1;
    restore(3'd4, 32'h0, pack_w1(32'h0, 20'h0, 9'h0), 32'h55, 1'b0, 1'b0);
    check_entry(3'd4, 32'h0, 20'h0, 9'h0, 16'h0055, "R2 allowed in system mode");
    sys_mgmt_i = 1'b0;
    dbg_mgmt_i = 1'b1;
    restore(3'd4, 32'h0, pack_w1(32'h0, 20'h0, 9'h0), 32'h66, 1'b0, 1'b0);
    check_entry(3'd4, 32'h0, 20'h0, 9'h0, 16'h0066, "R2 allowed in debug mode");
    dbg_mgmt_i = 1'b0;
    spec_en_i  = 1'b1;

    // R5 SS sets privilege, then R2 privilege fault
    restore(3'd2, 32'h0000_0FFF, pack_w1(32'h0000_0000, 20'h00FFF, 9'h022), 32'h0012, 1'b0, 1'b0);
    chk(cpl_o == 2'd2, "R5 cpl from DPL", 64'(cpl_o), 64'd2);
    try_fault(3'd0, "R2 cpl nonzero fault");
    check_entry(3'd0, 32'h0, 20'h0, 9'h0, 16'h0042, "R2 ES unchanged");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule